// File: doc/BRIEF.md
# Capture Pin Conditioning Front-End

This block turns an asynchronous external capture pin into a single clean internal capture level. It then raises a sticky capture interrupt flag and latches a timestamp. The pin is first brought into the clock domain by a two-stage synchronizer. From there it takes one of two routes to the capture level: a raw route, or a noise filter. The filter accepts a new level only after five consecutive samples agree, and it samples only on cycles where the sample-rate enable is high. A pin-function enable gates the selected level, and holds the capture level low whenever the pin is not assigned to capture.

Edges on the gated capture level are compared with an edge-select bit. When the direction matches, the flag is set and the value of a 16-bit free-running cycle counter is copied into the capture register. Both control bits act on the capture level cycle-exactly, so flipping them makes real edges. Those edges set the flag exactly as pin transitions do, which is why software is expected to clear the flag after reconfiguring the block.

Top module: `capture_frontend`

## Requirements
- R1: While `pinFuncEn` is 0, `capLevel` is 0 whatever the pin does, and no pin activity sets `capFlag`.
- R2: With `filterEn` 0 and `pinFuncEn` 1, a change on `pinIn` shows on `capLevel` exactly two clock edges later.
- R3: With `filterEn` 1, the filtered level takes a new pin value only on the fifth consecutive `sampleEn` sample of that value. A shorter run of a new level never reaches `capLevel`.
- R4: While `filterEn` is 0, the filter's run counter and held output are forced to 0, so re-enabling the filter starts it from a low level.
- R5: Setting `pinFuncEn` from 0 to 1 while the selected level is high gives a rising edge on `capLevel`. Clearing it while the level is high gives a falling edge.
- R6: Switching `filterEn` while `pinFuncEn` is 1, at a moment when the raw and filtered levels differ, makes an edge on `capLevel` that sets `capFlag` if its direction matches.
- R7: `edgeSel` = 1 selects rising edges and 0 selects falling edges. An edge in the other direction leaves `capFlag` unchanged.
- R8: `capFlag` is set on the clock edge that samples a matching edge. It stays set until a cycle with `flagClr` = 1 and no matching edge, after which it is 0.
- R9: A matching edge copies the counter value into `capValue`. The counter is 0 during reset and advances by one on every clock edge after reset, wrapping at 16 bits. Without a matching edge, `capValue` holds.
- R10: When `flagClr` and a matching edge fall in the same cycle, the edge wins and `capFlag` remains 1.
- R11: After reset, `capLevel`, `capFlag` and `capValue` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | External capture pin, asynchronous |
| pinFuncEn | input | 1 | Assigns the pin to capture; 0 forces the capture level low |
| filterEn | input | 1 | 1 selects the five-sample filter, 0 the raw synchronized pin |
| edgeSel | input | 1 | Active edge: 1 rising, 0 falling |
| sampleEn | input | 1 | Filter sample-rate pulse |
| flagClr | input | 1 | Software clear strobe for the capture flag |
| capLevel | output | 1 | Gated internal capture level |
| capFlag | output | 1 | Sticky capture interrupt flag |
| capValue | output | 16 | Counter value latched on the last matching edge |

## Verification
Three kinds of input patterns drive the block.

Clean pin steps on the raw path check the two-cycle synchronizer latency and the edge-direction match. Short glitches followed by long steady runs on the filtered path separate a filter that counts consecutive samples from one that counts in total or ignores `sampleEn`.

Reconfiguration sequences toggle `pinFuncEn` and `filterEn` with the pin held steady. These sequences show whether the spurious edges from control changes are produced and flagged. A clear strobe placed in the same cycle as a matching edge tests the set-over-clear priority.

A behavioural reference model is compared with every output on every cycle.

// File: rtl/capfe_pkg.sv
package capfe_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capLatch;  // copy the free-running count into the capture register
  } capStrobe_t;

  localparam int unsigned DEF_CNT_W    = 16;
  localparam int unsigned DEF_FILT_LEN = 5;
  localparam int unsigned DEF_SYNC     = 2;
endpackage

// File: rtl/capfe_sync.sv
module capfe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/capfe_filter.sv
module capfe_filter #(
  parameter int unsigned FILT_LEN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic sampleEn,
  input  logic levelIn,
  output logic levelOut
);
  localparam int unsigned RUN_W = $clog2(FILT_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

  logic [RUN_W-1:0] runCnt;
  logic             heldLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      heldLvl <= 1'b0;
    end else if (!enable) begin
      runCnt  <= '0;
      heldLvl <= 1'b0;
    end else if (sampleEn) begin
      if (levelIn == heldLvl) begin
        runCnt <= '0;
      end else if (runCnt == RUN_LAST) begin
        heldLvl <= levelIn;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign levelOut = heldLvl;

  // R3: the held level moves only on a sample pulse
  p_filt_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && enable && !$past(sampleEn)) |-> $stable(heldLvl));

  // R4: a disabled filter comes back low
  p_filt_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> !heldLvl);
endmodule

// File: rtl/capfe_datapath.sv
module capfe_datapath
  import capfe_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned FILT_LEN = DEF_FILT_LEN,
  parameter int unsigned SYNC     = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic             pinFuncEn,
  input  logic             filterEn,
  input  logic             sampleEn,
  input  capStrobe_t       strobe,
  output logic             capLevel,
  output logic [CNT_W-1:0] capValue
);
  logic syncPin;
  logic filtPin;
  logic selPin;
  logic [CNT_W-1:0] freeCnt;

  capfe_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(syncPin)
  );

  capfe_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk(clk), .rstN(rstN), .enable(filterEn), .sampleEn(sampleEn),
    .levelIn(syncPin), .levelOut(filtPin)
  );

  // Route select and pin-function gate are combinational on purpose:
  // control-bit changes reach the edge detector in the same cycle.
  always_comb begin
    selPin   = filterEn ? filtPin : syncPin;
    capLevel = pinFuncEn & selPin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) freeCnt <= '0;
    else       freeCnt <= freeCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               capValue <= '0;
    else if (strobe.capLatch) capValue <= freeCnt;
  end

  // R9: capture register holds between matching edges
  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.capLatch) |-> $stable(capValue));

  // R1: gated level is low while the pin is not assigned to capture
  p_gate_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!pinFuncEn && !$past(pinFuncEn)) |-> !$past(capLevel));
endmodule

// File: rtl/capfe_control.sv
module capfe_control
  import capfe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       capLevel,
  input  logic       edgeSel,
  input  logic       flagClr,
  output capStrobe_t strobe,
  output logic       capFlag
);
  logic prevLevel;
  logic riseDet;
  logic fallDet;
  logic matchDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= capLevel;
  end

  always_comb begin
    riseDet         = capLevel & ~prevLevel;
    fallDet         = ~capLevel & prevLevel;
    matchDet        = edgeSel ? riseDet : fallDet;
    strobe.capLatch = matchDet;
  end

  // Set has priority over the software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         capFlag <= 1'b0;
    else if (matchDet) capFlag <= 1'b1;
    else if (flagClr)  capFlag <= 1'b0;
  end

  // R8: flag is sticky without a clear
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClr) |=> capFlag);

  // R8: a clear with no edge drops the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !matchDet) |=> !capFlag);

  // R10: a matching edge wins over a same-cycle clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    matchDet |=> capFlag);

  // R7: a latch strobe only follows an edge in the selected direction
  p_edge_dir_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capLatch |-> (capLevel == edgeSel) && (capLevel != prevLevel));
endmodule

// File: rtl/capture_frontend.sv
module capture_frontend
  import capfe_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned FILT_LEN = DEF_FILT_LEN,
  parameter int unsigned SYNC     = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic             pinFuncEn,
  input  logic             filterEn,
  input  logic             edgeSel,
  input  logic             sampleEn,
  input  logic             flagClr,
  output logic             capLevel,
  output logic             capFlag,
  output logic [CNT_W-1:0] capValue
);
  capStrobe_t strobe;

  capfe_datapath #(.CNT_W(CNT_W), .FILT_LEN(FILT_LEN), .SYNC(SYNC)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinFuncEn(pinFuncEn),
    .filterEn(filterEn), .sampleEn(sampleEn), .strobe(strobe),
    .capLevel(capLevel), .capValue(capValue)
  );

  capfe_control u_ctl (
    .clk(clk), .rstN(rstN), .capLevel(capLevel), .edgeSel(edgeSel),
    .flagClr(flagClr), .strobe(strobe), .capFlag(capFlag)
  );
endmodule

// File: tb/capture_frontend_tb.sv
module capture_frontend_tb;
  localparam int DIV = 3;
  localparam int FLEN = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinIn = 1'b0, pinFuncEn = 1'b0, filterEn = 1'b0, edgeSel = 1'b0;
  logic sampleEn = 1'b0, flagClr = 1'b0;
  logic capLevel, capFlag;
  logic [15:0] capValue;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int mQ1, mQ2, mFl, mRun, mPrev, mFlag, mCap, mCnt;
  int divCnt = 0;

  always #5 clk = ~clk;

  capture_frontend u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinFuncEn(pinFuncEn),
    .filterEn(filterEn), .edgeSel(edgeSel), .sampleEn(sampleEn),
    .flagClr(flagClr), .capLevel(capLevel), .capFlag(capFlag),
    .capValue(capValue)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int modelLevel();
    int sel;
    sel = filterEn ? mFl : mQ2;
    return (pinFuncEn && sel) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int g, rise, fall, match;
    if (!rstN) begin
      mQ1 = 0; mQ2 = 0; mFl = 0; mRun = 0; mPrev = 0;
      mFlag = 0; mCap = 0; mCnt = 0;
    end else begin
      g = modelLevel();
      rise = (g == 1 && mPrev == 0) ? 1 : 0;
      fall = (g == 0 && mPrev == 1) ? 1 : 0;
      match = edgeSel ? rise : fall;
      if (match != 0) begin mFlag = 1; mCap = mCnt; end
      else if (flagClr) mFlag = 0;
      mPrev = g;
      if (!filterEn) begin mFl = 0; mRun = 0; end
      else if (sampleEn) begin
        if (mQ2 == mFl) mRun = 0;
        else if (mRun == FLEN - 1) begin mFl = mQ2; mRun = 0; end
        else mRun++;
      end
      mQ2 = mQ1;
      mQ1 = pinIn ? 1 : 0;
      mCnt = (mCnt + 1) & 16'hFFFF;
    end
  end

  // sample-rate pulse generator, driven at falling edges
  always @(negedge clk) begin
    divCnt = (divCnt + 1) % DIV;
    sampleEn = (divCnt == 0);
  end

  // compare every cycle, away from both clock edges
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      if (!pinFuncEn)
        check(capLevel == modelLevel(), "R1 level", capLevel, modelLevel());
      else if (filterEn)
        check(capLevel == modelLevel(), "R3 level", capLevel, modelLevel());
      else
        check(capLevel == modelLevel(), "R2 level", capLevel, modelLevel());
      check(capFlag == mFlag, "R8 flag", capFlag, mFlag);
      check(int'(capValue) == mCap, "R9 value", capValue, mCap);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look();
    #3;
  endtask

  task automatic clearFlag();
    flagClr = 1'b1;
    step(1);
    flagClr = 1'b0;
  endtask

  initial begin
    int expCap;
    step(3);
    rstN = 1'b1;
    look();
    check(capLevel == 0, "R11 level", capLevel, 0);
    check(capFlag == 0, "R11 flag", capFlag, 0);
    check(capValue == 0, "R11 value", capValue, 0);

    // R1: pin ignored while not assigned
    edgeSel = 1'b1;
    pinIn = 1'b1;
    step(6);
    look();
    check(capLevel == 0, "R1", capLevel, 0);
    check(capFlag == 0, "R1 flag", capFlag, 0);

    // R5 rising from enabling the pin function; R9 timestamp
    step(1);
    pinFuncEn = 1'b1;
    expCap = mCnt;
    step(1);
    look();
    check(capFlag == 1, "R5 rise", capFlag, 1);
    check(int'(capValue) == expCap, "R9", capValue, expCap);
    step(4);
    look();
    check(int'(capValue) == expCap, "R9 hold", capValue, expCap);
    step(1);
    clearFlag();
    look();
    check(capFlag == 0, "R8 clear", capFlag, 0);

    // R5 falling from disabling the pin function
    edgeSel = 1'b0;
    step(1);
    pinFuncEn = 1'b0;
    step(1);
    look();
    check(capFlag == 1, "R5 fall", capFlag, 1);
    clearFlag();

    // R7: rising edge ignored when falling is selected
    pinFuncEn = 1'b1;
    step(2);
    look();
    check(capLevel == 1, "R7 level", capLevel, 1);
    check(capFlag == 0, "R7", capFlag, 0);

    // R2: raw path latency of two edges
    step(1);
    pinIn = 1'b0;
    step(1);
    look();
    check(capLevel == 1, "R2 one edge", capLevel, 1);
    step(1);
    look();
    check(capLevel == 0, "R2 two edges", capLevel, 0);
    step(1);
    look();
    check(capFlag == 1, "R7 fall match", capFlag, 1);
    clearFlag();

    // R3: filtered path rejects a short run, accepts a long one
    filterEn = 1'b1;
    step(3);
    pinIn = 1'b1;
    step(2 * DIV);
    pinIn = 1'b0;
    step(12);
    look();
    check(capLevel == 0, "R3 glitch", capLevel, 0);
    pinIn = 1'b1;
    step(FLEN * DIV + 8);
    look();
    check(capLevel == 1, "R3 settled", capLevel, 1);
    clearFlag();

    // R4 and R6: brief filter disable resets it, re-enable yields a falling edge
    filterEn = 1'b0;
    step(1);
    filterEn = 1'b1;
    look();
    check(capLevel == 0, "R4", capLevel, 0);
    step(1);
    look();
    check(capFlag == 1, "R6", capFlag, 1);

    // R10: clear loses to a simultaneous matching edge (switch to raw = rise)
    step(1);
    edgeSel = 1'b1;
    filterEn = 1'b0;
    flagClr = 1'b1;
    step(1);
    flagClr = 1'b0;
    look();
    check(capFlag == 1, "R10", capFlag, 1);
    step(1);
    clearFlag();
    look();
    check(capFlag == 0, "R8 clear again", capFlag, 0);

    // R1: pin toggles with function disabled do not set the flag
    pinFuncEn = 1'b0;
    step(1);
    clearFlag();
    for (int i = 0; i < 6; i++) begin
      pinIn = ~pinIn;
      step(3);
    end
    look();
    check(capFlag == 0, "R1 toggles", capFlag, 0);
    step(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule